// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine moves one incoming Ethernet frame at a time into system memory. It uses descriptor rings that software has set up there. A frame arrives as a length handshake followed by a stream of bytes under valid/ready. The engine first searches up to four receive rings for a free descriptor. It then writes the frame bytes into that descriptor's buffer and hands the descriptor back to software. Finally it tells the register block to advance that ring's working pointer and pulses a receive-done cause strobe.

The engine reads ring heads, working pointers and the two-byte prefix option from the surrounding register block, and it reports pointer updates back to that block. All memory traffic goes through one simple 32-bit master port with request, write enable, address, write data, byte enables, read data and acknowledge. A descriptor is four little-endian 32-bit words at consecutive addresses:
- offset 0: command/status, where bit 31 is set while the hardware owns the descriptor;
- offset 4: received byte count in bits 15:0 and buffer capacity in bits 31:16;
- offset 8: buffer address;
- offset 12: address of the next descriptor.

A frame that finds no usable descriptor in any ring is consumed from the stream and thrown away without any memory write.

Top module: `rx_desc_dma`

## Requirements
- R1: While reset is high and after it releases, the engine shows `hdr_ready`=1, `dat_ready`=0, `mem_req`=0, `rx_done`=0 and `wptr_we`=0.
- R2: A descriptor is taken only if bit 31 of its word at offset 0 is 1 and the capacity in bits 31:16 of its word at offset 4 is at least the frame length. A capacity equal to the length is enough.
- R3: Rings are tried in ascending index order 0 to 3. A ring whose working pointer is zero is skipped. Once a descriptor is taken, no later ring is examined and the working pointers of all other rings stay unchanged.
- R4: Within a ring the walk starts at the working pointer and follows the next-descriptor word (offset 12). The ring is given up when that next address equals the ring head, so a descriptor between the head and the working pointer is not visited.
- R5: Frame byte i goes to byte address buffer + P + i, where P is 2 when `prefix_en` is 1 and 0 otherwise. Bytes are packed little-endian, so byte address a sits in lane a[1:0], bits 8*lane+7:8*lane. Byte enables leave every other byte of memory untouched.
- R6: After the last payload write, the engine writes offset 4 with the capacity unchanged and the count set to length + P. It then writes offset 0 with bit 31 cleared and bits 30:0 kept. No write of the frame follows the offset-0 write.
- R7: On acceptance the engine drives `wptr_we` for one cycle, with `wptr_idx` set to the ring and `wptr_val` set to the descriptor's next address. `rx_done` pulses in that same cycle, exactly once per accepted frame.
- R8: A frame with no usable descriptor in any ring has all of its `hdr_len` bytes drained. The engine makes no memory write, gives no `rx_done` pulse and does not change any working pointer.
- R9: Once `mem_req` is raised, it stays high with address and write enable stable until the cycle in which `mem_ack` is high.
- R10: `hdr_ready` is high only while the engine is idle. `dat_ready` is never high while a memory request is pending. No more than `hdr_len` bytes are accepted for a frame.
- R11: A zero-length frame that finds a descriptor makes no payload write. It still releases the descriptor, with the count equal to P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prefix_en | input | 1 | Leave a two-byte gap in front of the frame in the buffer |
| ring_head | input | NRINGS*32 | Head descriptor address of each ring, ring 0 in the low word |
| ring_wptr | input | NRINGS*32 | Working pointer of each ring, zero means the ring is unused |
| wptr_we | output | 1 | Working pointer update strobe |
| wptr_idx | output | RIW | Ring whose working pointer is updated |
| wptr_val | output | 32 | New working pointer value |
| rx_done | output | 1 | Receive-done cause strobe (cause bit 0) |
| hdr_valid | input | 1 | Frame length valid |
| hdr_len | input | LEN_W | Frame length in bytes |
| hdr_ready | output | 1 | Engine idle and taking a new frame length |
| dat_valid | input | 1 | Frame byte valid |
| dat_byte | input | 8 | Frame byte |
| dat_ready | output | 1 | Engine taking a frame byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address, word aligned for descriptor accesses |
| mem_wdata | output | 32 | Memory write data |
| mem_be | output | 4 | Memory byte enables |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Every cycle, the assertions check the request-hold rule of the memory port and that the frame stream never runs past its declared length. They also check that the ownership word is written back with bit 31 clear and that the completion strobe comes straight after an acknowledged write. Inside the packer they check that no byte lane is loaded twice before a flush. Only the bench scenarios can show the search outcome: the ring order, the walk stopping at the head, the exact-fit and one-short capacities, and the drop path. Comparing the whole memory image against a model shows the byte placement with and without the prefix and the write-back contents. The bench also watches the order of the payload and release writes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 16;
  localparam int OWN_BIT    = 31;
  localparam int DESC_WORDS = 4;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PICK,
    S_RD,
    S_EVAL,
    S_PAY,
    S_PWR,
    S_WB1,
    S_WB0,
    S_DONE,
    S_DRAIN
  } rxd_state_e;
endpackage

// File: rtl/rxd_ring_pick.sv
module rxd_ring_pick #(
  parameter int NRINGS = 4,
  parameter int RIW    = 2
) (
  input  logic [NRINGS-1:0] live,
  input  logic [RIW:0]      start,
  output logic              found,
  output logic [RIW-1:0]    idx
);
  // lowest live ring at or above start wins
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NRINGS - 1; i >= 0; i--) begin
      if (live[i] && (i >= int'(start))) begin
        found = 1'b1;
        idx   = RIW'(i);
      end
    end
  end
endmodule

// File: rtl/rxd_lane_pack.sv
module rxd_lane_pack (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic        clr,
  input  logic [1:0]  lane,
  input  logic [7:0]  din,
  output logic [31:0] word,
  output logic [3:0]  be
);
  for (genvar g = 0; g < 4; g++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        byte_q <= '0;
        be[g]  <= 1'b0;
      end else if (load && (lane == 2'(g))) begin
        byte_q <= din;
        be[g]  <= 1'b1;
      end
    end
    assign word[g*8 +: 8] = byte_q;
  end

  // R5: a lane is filled at most once per flushed word
  assert_lane_free_R5: assert property (@(posedge clk) disable iff (rst)
    load |-> !be[lane]);
  assert_no_load_on_flush_R5: assert property (@(posedge clk) disable iff (rst)
    clr |-> !load);
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int NRINGS = 4,
  parameter int LEN_W  = 16,
  localparam int RIW   = (NRINGS > 1) ? $clog2(NRINGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 prefix_en,
  input  logic [NRINGS*32-1:0] ring_head,
  input  logic [NRINGS*32-1:0] ring_wptr,
  output logic                 wptr_we,
  output logic [RIW-1:0]       wptr_idx,
  output logic [31:0]          wptr_val,
  output logic                 rx_done,
  input  logic                 hdr_valid,
  input  logic [LEN_W-1:0]     hdr_len,
  output logic                 hdr_ready,
  input  logic                 dat_valid,
  input  logic [7:0]           dat_byte,
  output logic                 dat_ready,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [31:0]          mem_addr,
  output logic [31:0]          mem_wdata,
  output logic [3:0]           mem_be,
  input  logic [31:0]          mem_rdata,
  input  logic                 mem_ack
);
  import rxd_pkg::*;

  localparam int WI_W = $clog2(DESC_WORDS);

  rxd_state_e         state;
  logic [LEN_W-1:0]   len_q, left;
  logic               pre_q;
  logic [RIW:0]       start;
  logic [RIW-1:0]     ring;
  logic [ADDR_W-1:0]  dsc_addr, bufa, nxt, baddr, pwaddr;
  logic [WORD_W-1:0]  cmd;
  logic [CNT_W-1:0]   bsize;
  logic [WI_W-1:0]    wi;

  logic [NRINGS-1:0]  live;
  logic               pick_found;
  logic [RIW-1:0]     pick_idx;
  logic [ADDR_W-1:0]  head_sel;
  logic [CNT_W-1:0]   cnt_val;
  logic               fits;
  logic               pk_load, pk_clr;
  logic [31:0]        pk_word;
  logic [3:0]         pk_be;

  for (genvar g = 0; g < NRINGS; g++) begin : g_live
    assign live[g] = |ring_wptr[g*32 +: 32];
  end

  rxd_ring_pick #(.NRINGS(NRINGS), .RIW(RIW)) u_pick (
    .live  (live),
    .start (start),
    .found (pick_found),
    .idx   (pick_idx)
  );

  assign head_sel = ring_head[ring*32 +: 32];
  assign cnt_val  = CNT_W'(len_q) + (pre_q ? CNT_W'(2) : CNT_W'(0));
  assign fits     = cmd[OWN_BIT] && (bsize >= CNT_W'(len_q));
  assign pk_load  = (state == S_PAY) && dat_valid;
  assign pk_clr   = (state == S_PWR) && mem_ack;

  rxd_lane_pack u_pack (
    .clk  (clk),
    .rst  (rst),
    .load (pk_load),
    .clr  (pk_clr),
    .lane (baddr[1:0]),
    .din  (dat_byte),
    .word (pk_word),
    .be   (pk_be)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      len_q    <= '0;
      left     <= '0;
      pre_q    <= 1'b0;
      start    <= '0;
      ring     <= '0;
      dsc_addr <= '0;
      bufa     <= '0;
      nxt      <= '0;
      baddr    <= '0;
      pwaddr   <= '0;
      cmd      <= '0;
      bsize    <= '0;
      wi       <= '0;
    end else begin
      case (state)
        S_IDLE: if (hdr_valid) begin
          len_q <= hdr_len;
          left  <= hdr_len;
          pre_q <= prefix_en;
          start <= '0;
          state <= S_PICK;
        end
        S_PICK: begin
          if (pick_found) begin
            ring     <= pick_idx;
            dsc_addr <= ring_wptr[pick_idx*32 +: 32];
            wi       <= '0;
            state    <= S_RD;
          end else begin
            state <= (left == '0) ? S_IDLE : S_DRAIN;
          end
        end
        S_RD: if (mem_ack) begin
          case (wi)
            2'd0:    cmd   <= mem_rdata;
            2'd1:    bsize <= mem_rdata[31:16];
            2'd2:    bufa  <= mem_rdata;
            default: nxt   <= mem_rdata;
          endcase
          wi <= wi + 1'b1;
          if (wi == WI_W'(DESC_WORDS - 1)) state <= S_EVAL;
        end
        S_EVAL: begin
          if (fits) begin
            baddr <= bufa + (pre_q ? 32'd2 : 32'd0);
            state <= (len_q == '0) ? S_WB1 : S_PAY;
          end else if (nxt == head_sel) begin
            start <= {1'b0, ring} + 1'b1;
            state <= S_PICK;
          end else begin
            dsc_addr <= nxt;
            wi       <= '0;
            state    <= S_RD;
          end
        end
        S_PAY: if (dat_valid) begin
          left   <= left - 1'b1;
          baddr  <= baddr + 1'b1;
          pwaddr <= {baddr[31:2], 2'b00};
          if ((baddr[1:0] == 2'd3) || (left == LEN_W'(1))) state <= S_PWR;
        end
        S_PWR: if (mem_ack) state <= (left == '0) ? S_WB1 : S_PAY;
        S_WB1: if (mem_ack) state <= S_WB0;
        S_WB0: if (mem_ack) state <= S_DONE;
        S_DONE: state <= S_IDLE;
        S_DRAIN: if (dat_valid) begin
          left <= left - 1'b1;
          if (left == LEN_W'(1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // outputs decoded from state flops only
  assign hdr_ready = (state == S_IDLE);
  assign dat_ready = (state == S_PAY) || (state == S_DRAIN);
  assign mem_req   = (state == S_RD) || (state == S_PWR) || (state == S_WB1) || (state == S_WB0);
  assign mem_we    = (state == S_PWR) || (state == S_WB1) || (state == S_WB0);
  assign wptr_we   = (state == S_DONE);
  assign rx_done   = (state == S_DONE);
  assign wptr_idx  = ring;
  assign wptr_val  = nxt;

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    mem_be    = '0;
    case (state)
      S_RD: begin
        mem_addr = dsc_addr + {{(ADDR_W-WI_W-2){1'b0}}, wi, 2'b00};
        mem_be   = 4'hF;
      end
      S_PWR: begin
        mem_addr  = pwaddr;
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      S_WB1: begin
        mem_addr  = dsc_addr + 32'd4;
        mem_wdata = {bsize, cnt_val};
        mem_be    = 4'hF;
      end
      S_WB0: begin
        mem_addr  = dsc_addr;
        mem_wdata = cmd & ~(32'd1 << OWN_BIT);
        mem_be    = 4'hF;
      end
      default: ;
    endcase
  end

  // R9: request held with stable address and direction until acknowledged
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  // R10: the stream never delivers more bytes than announced
  assert_frame_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (dat_valid && dat_ready) |-> (left != '0));
  // R10: no memory traffic while waiting for a frame
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    hdr_ready |-> !mem_req);
  // R6: the word written at the descriptor base releases ownership
  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && (mem_be == 4'hF) && (mem_addr == dsc_addr)) |-> !mem_wdata[OWN_BIT]);
  // R7: completion follows an acknowledged write
  assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (rst)
    rx_done |-> $past(mem_req && mem_we && mem_ack));
endmodule

// File: tb/rx_desc_dma_test.sv
`timescale 1ns/1ps
module rx_desc_dma_test;
  logic         clk = 1'b0;
  logic         rst;
  logic         prefix_en;
  logic [127:0] ring_head, ring_wptr;
  logic         wptr_we;
  logic [1:0]   wptr_idx;
  logic [31:0]  wptr_val;
  logic         rx_done;
  logic         hdr_valid;
  logic [15:0]  hdr_len;
  logic         hdr_ready;
  logic         dat_valid;
  logic [7:0]   dat_byte;
  logic         dat_ready;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr, mem_wdata, mem_rdata;
  logic [3:0]   mem_be;
  logic         mem_ack;

  always #2.5 clk = ~clk;

  rx_desc_dma uut (
    .clk(clk), .rst(rst), .prefix_en(prefix_en),
    .ring_head(ring_head), .ring_wptr(ring_wptr),
    .wptr_we(wptr_we), .wptr_idx(wptr_idx), .wptr_val(wptr_val),
    .rx_done(rx_done),
    .hdr_valid(hdr_valid), .hdr_len(hdr_len), .hdr_ready(hdr_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  logic [31:0] mem  [0:1023];
  logic [31:0] xmem [0:1023];
  logic [31:0] wptr [0:3];
  logic [31:0] xwptr[0:3];
  logic [31:0] head [0:3];
  logic [7:0]  fb   [0:63];

  logic        cfg_mem_we = 1'b0;
  logic [9:0]  cfg_idx = '0;
  logic [31:0] cfg_val = '0;
  logic        cfg_wp_we = 1'b0;
  logic [1:0]  cfg_wi = '0;
  logic [31:0] cfg_wv = '0;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, hold_err = 0, bp_err = 0, ord_err = 0, oob_err = 0;
  int frame_id = 0, rel_frame = -1;
  logic [31:0] last_wa = '0;
  logic p_req = 1'b0, p_ack = 1'b0;
  logic [31:0] p_addr = '0;
  bit finished = 0;

  assign ring_head = {head[3], head[2], head[1], head[0]};
  assign ring_wptr = {wptr[3], wptr[2], wptr[1], wptr[0]};

  // memory model with random acknowledge delay and write-order monitor
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (cfg_mem_we) mem[cfg_idx] <= cfg_val;
    else if (mem_req && !mem_ack && (($urandom % 4) != 0)) begin
      mem_ack <= 1'b1;
      if (mem_addr >= 32'd4096) oob_err <= oob_err + 1;
      else if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
        if (rel_frame == frame_id) ord_err <= ord_err + 1;
        if (mem_addr >= 32'h100 && mem_addr < 32'h1C0 && mem_addr[3:0] == 4'h0) begin
          if (last_wa != mem_addr + 32'd4) ord_err <= ord_err + 1;
          rel_frame <= frame_id;
        end
        last_wa <= mem_addr;
      end else mem_rdata <= mem[mem_addr[11:2]];
    end
  end

  always @(posedge clk) begin
    if (cfg_wp_we) wptr[cfg_wi] <= cfg_wv;
    else if (wptr_we) wptr[wptr_idx] <= wptr_val;
    if (rx_done) done_cnt <= done_cnt + 1;
    if (!rst && p_req && !p_ack && (!mem_req || mem_addr != p_addr)) hold_err <= hold_err + 1;
    p_req  <= mem_req;
    p_ack  <= mem_ack;
    p_addr <= mem_addr;
  end

  always @(negedge clk) if (!rst && ((dat_ready && mem_req) || (hdr_ready && mem_req))) bp_err <= bp_err + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic poke(input int idx, input logic [31:0] val);
    cfg_mem_we = 1'b1; cfg_idx = 10'(idx); cfg_val = val; xmem[idx] = val;
    @(negedge clk);
    cfg_mem_we = 1'b0;
  endtask

  task automatic setwp(input int r, input logic [31:0] val);
    cfg_wp_we = 1'b1; cfg_wi = 2'(r); cfg_wv = val; xwptr[r] = val;
    @(negedge clk);
    cfg_wp_we = 1'b0;
  endtask

  task automatic build_rings(input logic [11:0] own_m, input logic [3:0] en_m,
                             input int fsize, input int st);
    for (int r = 0; r < 4; r++) begin
      head[r] = 32'h100 + 32'(r * 64);
      for (int d = 0; d < 4 - 1; d++) begin
        int base = 32'h100 + r * 64 + d * 16;
        int sz = (fsize >= 0) ? fsize : int'($urandom % 49);
        poke(base / 4,     {own_m[r*3+d], 31'($urandom)});
        poke(base / 4 + 1, {16'(sz), 16'($urandom)});
        poke(base / 4 + 2, 32'h400 + 32'((r*3 + d) * 64) + ($urandom % 4));
        poke(base / 4 + 3, 32'h100 + 32'(r * 64 + ((d + 1) % 3) * 16));
      end
      setwp(r, en_m[r] ? head[r] + 32'(((st < 0) ? int'($urandom % 3) : st) * 16) : 32'h0);
    end
  endtask

  // expected outcome from the requirements (R2-R8, R11)
  task automatic ref_frame(input int len, input bit pre, output bit acc);
    int p = pre ? 2 : 0;
    acc = 0;
    for (int r = 0; r < 4; r++) begin
      if (!acc && xwptr[r] != 0) begin
        logic [31:0] a = xwptr[r];
        int steps = 0;
        do begin
          logic [31:0] w0 = xmem[a[11:2]];
          logic [31:0] w1 = xmem[a[11:2] + 1];
          logic [31:0] w2 = xmem[a[11:2] + 2];
          logic [31:0] w3 = xmem[a[11:2] + 3];
          if (w0[31] && int'(w1[31:16]) >= len) begin
            for (int i = 0; i < len; i++) begin
              logic [31:0] ba = w2 + 32'(p + i);
              xmem[ba[11:2]][8*ba[1:0] +: 8] = fb[i];
            end
            xmem[a[11:2] + 1] = {w1[31:16], 16'(len + p)};
            xmem[a[11:2]] = w0 & 32'h7FFF_FFFF;
            xwptr[r] = w3;
            acc = 1;
          end else a = w3;
          steps++;
        end while (!acc && a != head[r] && steps < 16);
      end
    end
  endtask

  task automatic send_frame(input int len);
    hdr_len = 16'(len); hdr_valid = 1'b1;
    while (!hdr_ready) @(negedge clk);
    @(negedge clk);
    hdr_valid = 1'b0;
    for (int i = 0; i < len; i++) begin
      dat_valid = 1'b0;
      repeat ($urandom % 3) @(negedge clk);
      dat_valid = 1'b1; dat_byte = fb[i];
      while (!dat_ready) @(negedge clk);
      @(negedge clk);
    end
    dat_valid = 1'b0;
    while (!hdr_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(input logic [11:0] own_m, input logic [3:0] en_m,
                           input int fsize, input int st, input int len,
                           input bit pre, input string tag);
    bit acc;
    int d0, bad = 0, first = -1;
    build_rings(own_m, en_m, fsize, st);
    prefix_en = pre;
    for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
    frame_id++;
    d0 = done_cnt;
    ref_frame(len, pre, acc);
    send_frame(len);
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== xmem[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, acc ? "R5/R6" : "R8", $sformatf("%s memory image word %0d", tag, first),
        (first < 0) ? 32'h0 : mem[first], (first < 0) ? 32'h0 : xmem[first]);
    for (int r = 0; r < 4; r++)
      if (wptr[r] !== xwptr[r]) chk(0, "R7", $sformatf("%s wptr ring %0d", tag, r), wptr[r], xwptr[r]);
    chk(1, "R7", "wptr tally", 0, 0);
    chk((done_cnt - d0) == int'(acc), acc ? "R7" : "R8", {tag, " done pulses"},
        32'(done_cnt - d0), 32'(acc));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; prefix_en = 1'b0; hdr_valid = 1'b0; hdr_len = '0;
    dat_valid = 1'b0; dat_byte = '0;
    for (int r = 0; r < 4; r++) head[r] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(hdr_ready && !dat_ready && !mem_req && !rx_done && !wptr_we, "R1", "reset outputs",
        {27'd0, hdr_ready, dat_ready, mem_req, rx_done, wptr_we}, 32'h10);
    rst = 1'b0;
    @(negedge clk);
    chk(hdr_ready && !mem_req, "R1", "after release", {30'd0, hdr_ready, mem_req}, 32'h2);
    for (int i = 0; i < 1024; i++) poke(i, $urandom);
    for (int r = 0; r < 4; r++) setwp(r, 32'h0);

    run_frame(12'hFFF, 4'h0, -1, -1, 20, 0, "R8 all rings off");
    run_frame(12'h000, 4'hF, -1, -1, 10, 1, "R8 nothing owned");
    run_frame(12'hFFF, 4'hE, 48, -1, 17, 0, "R3 ring0 off");
    run_frame(12'hFFF, 4'h1, 33, -1, 33, 1, "R2 exact fit");
    run_frame(12'hFFF, 4'hF, 32, -1, 33, 0, "R2 one short");
    run_frame(12'b000000100010, 4'h3, 48, 2, 9, 1, "R4 stop at head");
    run_frame(12'hFFF, 4'hF, -1, -1, 0, 1, "R11 empty frame");
    run_frame(12'hFFF, 4'hF, 48, -1, 1, 1, "R5 single byte");
    for (int k = 0; k < 45; k++)
      run_frame(12'($urandom), 4'($urandom), -1, -1, int'($urandom % 49), 1'($urandom),
                "random");

    chk(hold_err == 0, "R9", "request dropped or moved before ack", 32'(hold_err), 0);
    chk(bp_err == 0, "R10", "ready while request pending", 32'(bp_err), 0);
    chk(ord_err == 0, "R6", "write-back order", 32'(ord_err), 0);
    chk(oob_err == 0, "R5", "address out of range", 32'(oob_err), 0);
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected idle");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    end
    $finish;
  end
endmodule